// File: doc/BRIEF.md
# Hash Unit End-of-Message Controller

This block sits beside an external hash core and decides what happens when a message ends. Software writes a 64-bit mode word and an ICV size. A job then starts: message bytes are pulled from a byte-wide input FIFO and passed straight to the core. When the last byte arrives, the controller issues one command to the core. The command carries the algorithm, whether to autopad, whether to complete the digest or keep state for a later job, and how many bytes to hash.

In TLS-inbound block-cipher mode, the last message byte is a pad length. The controller trims the hashed length to the byte count minus that pad length minus one. If the pad length does not fit in the message, it reports a size error and issues no command. When compare mode is set and the digest is being completed, the controller reads an expected ICV of the programmed length from the FIFO after the core finishes. It compares that ICV with the digest, starting at the most significant byte. A mismatch sets the error output. The error output stays set until the next accepted register write.

The mode word uses big-endian bit numbering: mode bit n is vector index 63-n. The error cause bits are sticky and are encoded as follows: `err_cause[2]` is a configuration error, `err_cause[1]` is a size error and `err_cause[0]` is an ICV mismatch. Each job ends with a one-cycle `done` pulse.

Top module: `hash_eom_ctrl`

## Requirements
- R1: The algorithm field (mode bits 62–63, vector index [1:0]) is driven on `core_alg` with the codes 00 = SHA-1, 01 = SHA-256, 10 = MD5 and 11 = SHA-224.
- R2: With continue clear (mode bit 56, index 7 = 0), the end-of-message command has `core_cmd_pad`=1 and `core_cmd_final`=1. Without TLS trimming, `core_len` equals the number of message bytes.
- R3: With continue set, the command has `core_cmd_pad`=0 and `core_cmd_final`=0. No ICV is read, and the job ends with no error.
- R4: A mode write is rejected when any of these holds: bit 61 (index 2) equals bit 56, bit 54 (index 9) is 0, or bit 55 (index 8) is 1. A rejected write sets `err` with cause 3'b100 and leaves the stored mode unchanged. Any accepted write (`cfg_sel`=0 mode, `cfg_sel`=1 ICV size in bits [5:0]) clears `err` and `err_cause`.
- R5: With TLS mode set (bit 53, index 10), `core_len` = byte count − last byte − 1.
- R6: In TLS mode, when the last byte + 1 exceeds the byte count, the job sets cause 3'b010, issues no core command and still pulses `done`.
- R7: With compare set (bit 57, index 6) and continue clear, ICV-size bytes are read after `core_done`. Byte k is compared with `core_digest[255-8k -: 8]`, and any difference sets cause 3'b001.
- R8: When compare is active, the ICV size must lie between 1 and the digest length (20, 32, 16 or 28 bytes by algorithm). Otherwise the start sets cause 3'b100, reads nothing, issues no command and pulses `done`.
- R9: Every started job produces exactly one `done` pulse, and each pulse is exactly one cycle long.
- R10: `err` stays asserted until an accepted write or a reset. While `err` is asserted, `job_start` is ignored.
- R11: Register writes made while a job is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = mode word, 1 = ICV size |
| cfg_wdata | input | 64 | Write data |
| job_start | input | 1 | Start a job (accepted when idle and no error) |
| fifo_valid | input | 1 | Input FIFO has a byte |
| fifo_data | input | 8 | Input FIFO byte |
| fifo_last | input | 1 | Marks the last message byte |
| fifo_rd | output | 1 | Pops the FIFO when `fifo_valid` is high |
| core_byte_valid | output | 1 | Message byte passed to the core |
| core_byte | output | 8 | Message byte to the core |
| core_alg | output | 2 | Algorithm code |
| core_cmd_valid | output | 1 | End-of-message command request |
| core_cmd_pad | output | 1 | Command: autopad |
| core_cmd_final | output | 1 | Command: complete the digest |
| core_len | output | 16 | Command: bytes to hash |
| core_ready | input | 1 | Core accepts the command |
| core_done | input | 1 | Core finished the command |
| core_digest | input | 256 | Digest, most significant byte in [255:248] |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Sticky error |
| err_cause | output | 3 | Sticky cause: [2] config, [1] size, [0] ICV |

## Verification
Two functions can fall on the same path: TLS trimming and ICV comparison. Both take bytes from the same FIFO port, and the boundary between message bytes and ICV bytes moves with the pad length. The bench runs jobs that combine a trimmed length of zero with completion, and jobs that combine a full 20-byte comparison with an error on the last compared byte. It judges each job by the captured command fields, the count of `done` pulses and the final cause bits. Writes made during a running job are checked against the command the job later issues.

// File: rtl/hec_pkg.sv
package hec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ABSORB, ST_TRIM, ST_FINALIZE, ST_COMPARE, ST_DONE
    } hec_state_e;

    // digest length in bytes for each algorithm code
    function automatic logic [5:0] dig_bytes(input logic [1:0] alg);
        case (alg)
            2'b00:   return 6'd20;
            2'b01:   return 6'd32;
            2'b10:   return 6'd16;
            default: return 6'd28;
        endcase
    endfunction
endpackage

// File: rtl/hec_mode_dec.sv
module hec_mode_dec (
    input  logic [63:0] word,
    output logic [1:0]  alg,
    output logic        cont,
    output logic        cicv,
    output logic        tls,
    output logic        ok
);
    // big-endian numbering: mode bit n sits at vector index 63-n
    localparam int IX_TLS  = 63 - 53;
    localparam int IX_NEW  = 63 - 54;
    localparam int IX_RSV  = 63 - 55;
    localparam int IX_CONT = 63 - 56;
    localparam int IX_CICV = 63 - 57;
    localparam int IX_INV  = 63 - 61;

    always_comb begin
        alg  = word[1:0];
        cont = word[IX_CONT];
        cicv = word[IX_CICV];
        tls  = word[IX_TLS];
        ok   = word[IX_NEW] && !word[IX_RSV] && (word[IX_INV] != word[IX_CONT]);
    end
endmodule

// File: rtl/hec_byte_pick.sv
module hec_byte_pick #(
    parameter int DIG_W = 256,
    localparam int NBYTES = DIG_W / 8,
    localparam int IX_W = $clog2(NBYTES)
) (
    input  logic [DIG_W-1:0] digest,
    input  logic [IX_W-1:0]  idx,
    output logic [7:0]       byte_o
);
    logic [7:0] bytes [NBYTES];
    for (genvar g = 0; g < NBYTES; g++) begin : g_split
        assign bytes[g] = digest[DIG_W-1-8*g -: 8];
    end
    assign byte_o = bytes[idx];
endmodule

// File: rtl/hash_eom_ctrl.sv
module hash_eom_ctrl
    import hec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIG_W = 256,
    localparam int IX_W = $clog2(DIG_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [63:0]      cfg_wdata,
    input  logic             job_start,
    input  logic             fifo_valid,
    input  logic [7:0]       fifo_data,
    input  logic             fifo_last,
    output logic             fifo_rd,
    output logic             core_byte_valid,
    output logic [7:0]       core_byte,
    output logic [1:0]       core_alg,
    output logic             core_cmd_valid,
    output logic             core_cmd_pad,
    output logic             core_cmd_final,
    output logic [CNT_W-1:0] core_len,
    input  logic             core_ready,
    input  logic             core_done,
    input  logic [DIG_W-1:0] core_digest,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_cause
);
    typedef struct packed {
        hec_state_e       st;
        logic [63:0]      mode;
        logic [5:0]       icv_sz;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       last_b;
        logic [CNT_W-1:0] len;
        logic             sent;
        logic [IX_W-1:0]  idx;
        logic             miss;
        logic [DIG_W-1:0] dig;
        logic             err;
        logic [2:0]       cause;
    } regs_t;

    regs_t r_q, r_d;

    logic [1:0] alg_q, alg_w;
    logic       cont_q, cicv_q, tls_q, ok_q, cont_w, cicv_w, tls_w, ok_w;
    logic [7:0] exp_byte;

    hec_mode_dec u_dec_q (.word(r_q.mode), .alg(alg_q), .cont(cont_q), .cicv(cicv_q), .tls(tls_q), .ok(ok_q));
    hec_mode_dec u_dec_w (.word(cfg_wdata), .alg(alg_w), .cont(cont_w), .cicv(cicv_w), .tls(tls_w), .ok(ok_w));
    hec_byte_pick #(.DIG_W(DIG_W)) u_pick (.digest(r_q.dig), .idx(r_q.idx), .byte_o(exp_byte));

    logic       cmp_on;
    logic [5:0] dlen;
    logic [CNT_W:0] need;
    assign cmp_on = cicv_q && !cont_q;
    assign dlen   = dig_bytes(alg_q);
    assign need   = {{(CNT_W-7){1'b0}}, r_q.last_b} + 1'b1;

    always_comb begin
        r_d             = r_q;
        done            = 1'b0;
        fifo_rd         = 1'b0;
        core_cmd_valid  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cfg_we) begin
                    if (cfg_sel) begin
                        r_d.icv_sz = cfg_wdata[5:0];
                        r_d.err    = 1'b0;
                        r_d.cause  = 3'b000;
                    end else if (ok_w) begin
                        r_d.mode  = cfg_wdata;
                        r_d.err   = 1'b0;
                        r_d.cause = 3'b000;
                    end else begin
                        r_d.err   = 1'b1;
                        r_d.cause = 3'b100;
                    end
                end else if (job_start && !r_q.err) begin
                    r_d.cnt  = '0;
                    r_d.sent = 1'b0;
                    r_d.miss = 1'b0;
                    r_d.idx  = '0;
                    if (cmp_on && (r_q.icv_sz == 6'd0 || r_q.icv_sz > dlen)) begin
                        r_d.err   = 1'b1;
                        r_d.cause = 3'b100;
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.st = ST_ABSORB;
                    end
                end
            end
            ST_ABSORB: begin
                fifo_rd = 1'b1;
                if (fifo_valid) begin
                    r_d.cnt    = r_q.cnt + 1'b1;
                    r_d.last_b = fifo_data;
                    if (fifo_last) begin
                        r_d.len = r_q.cnt + 1'b1;
                        r_d.st  = tls_q ? ST_TRIM : ST_FINALIZE;
                    end
                end
            end
            ST_TRIM: begin
                if (need > {1'b0, r_q.cnt}) begin
                    r_d.err   = 1'b1;
                    r_d.cause = r_q.cause | 3'b010;
                    r_d.st    = ST_DONE;
                end else begin
                    r_d.len = r_q.cnt - need[CNT_W-1:0];
                    r_d.st  = ST_FINALIZE;
                end
            end
            ST_FINALIZE: begin
                core_cmd_valid = !r_q.sent;
                if (core_cmd_valid && core_ready) r_d.sent = 1'b1;
                if (r_q.sent && core_done) begin
                    r_d.dig = core_digest;
                    r_d.st  = cmp_on ? ST_COMPARE : ST_DONE;
                end
            end
            ST_COMPARE: begin
                fifo_rd = 1'b1;
                if (fifo_valid) begin
                    r_d.miss = r_q.miss | (fifo_data != exp_byte);
                    r_d.idx  = r_q.idx + 1'b1;
                    if ({{(6-IX_W){1'b0}}, r_q.idx} == r_q.icv_sz - 6'd1) begin
                        r_d.st = ST_DONE;
                        if (r_d.miss) begin
                            r_d.err   = 1'b1;
                            r_d.cause = r_q.cause | 3'b001;
                        end
                    end
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.mode <= 64'h0000_0000_0000_0204; // new layout, continue clear, inverse bit set
        end else begin
            r_q <= r_d;
        end
    end

    assign core_byte_valid = (r_q.st == ST_ABSORB) && fifo_valid;
    assign core_byte       = fifo_data;
    assign core_alg        = alg_q;
    assign core_cmd_pad    = !cont_q;
    assign core_cmd_final  = !cont_q;
    assign core_len        = r_q.len;
    assign err             = r_q.err;
    assign err_cause       = r_q.cause;

    // R9: done lasts one cycle
    p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R10: error holds without a write
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n) (err && !cfg_we) |=> err);
    // R2/R3: command fields hold while waiting for the core
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cmd_valid && !core_ready) |=> (core_cmd_valid && $stable(core_len) && $stable(core_cmd_pad)));
    // R7: no FIFO pop while a command is outstanding
    p_no_pop_in_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n) core_cmd_valid |-> !fifo_rd);
    // R6: size error never followed by a command in the same job
    p_len_err_no_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_cause[1]) |-> !core_cmd_valid);
    // R11: mode seen by the core is stable while busy
    p_alg_stable_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(core_alg));
endmodule

// File: tb/tb_hash_eom_ctrl.sv
module tb_hash_eom_ctrl;
    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic cfg_we = 0, cfg_sel = 0; logic [63:0] cfg_wdata = '0;
    logic job_start = 0, fifo_valid = 0, fifo_last = 0; logic [7:0] fifo_data = '0;
    logic fifo_rd, core_byte_valid, core_cmd_valid, core_cmd_pad, core_cmd_final;
    logic [7:0] core_byte; logic [1:0] core_alg; logic [15:0] core_len;
    logic core_ready = 1, core_done = 0;
    logic done, err; logic [2:0] err_cause;
    localparam logic [255:0] DIG = 256'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [255:0] core_digest = DIG;

    hash_eom_ctrl dut (.*);

    int checks = 0, fails = 0, done_cnt = 0;
    logic cmd_seen = 0, pend = 0, c_pad, c_fin; logic [1:0] c_alg; logic [15:0] c_len;
    bit finished = 0;

    always @(negedge clk) begin
        if (done) done_cnt++;
        core_done <= 1'b0;
        if (pend) begin core_done <= 1'b1; pend <= 1'b0; end
        else if (core_cmd_valid && !core_done) begin
            pend <= 1'b1; cmd_seen <= 1'b1;
            c_alg <= core_alg; c_pad <= core_cmd_pad; c_fin <= core_cmd_final; c_len <= core_len;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [1:0] alg, logic cont, logic cicv, logic tls);
        logic [63:0] m = '0;
        m[9] = 1'b1; m[7] = cont; m[2] = ~cont; m[6] = cicv; m[10] = tls; m[1:0] = alg;
        return m;
    endfunction

    task automatic wr(logic sel, logic [63:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d; @(negedge clk); cfg_we = 0;
    endtask
    task automatic go();
        job_start = 1; @(negedge clk); job_start = 0;
    endtask
    task automatic push(logic [7:0] b, logic last);
        int t = 0;
        fifo_valid = 1; fifo_data = b; fifo_last = last;
        while (!fifo_rd && t < 50) begin @(negedge clk); t++; end
        @(negedge clk); fifo_valid = 0; fifo_last = 0;
    endtask
    function automatic logic [7:0] dbyte(int k);
        return DIG[255-8*k -: 8];
    endfunction

    typedef struct packed {
        logic [1:0] alg; logic cont; logic cicv; logic tls; logic [5:0] icv;
        logic [7:0] n; logic [7:0] pad; logic bad; logic [2:0] ecause; logic [7:0] elen; logic ecmd;
    } vec_t;
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd5,  8'd0, 1'b0, 3'b000, 8'd5, 1'b1}, // R1 R2 sha1 plain
        '{2'd1, 1'b1, 1'b0, 1'b0, 6'd0,  8'd7,  8'd0, 1'b0, 3'b000, 8'd7, 1'b1}, // R3 continue
        '{2'd2, 1'b0, 1'b1, 1'b0, 6'd16, 8'd3,  8'd0, 1'b0, 3'b000, 8'd3, 1'b1}, // R7 md5 full icv match
        '{2'd3, 1'b0, 1'b1, 1'b0, 6'd4,  8'd2,  8'd0, 1'b1, 3'b001, 8'd2, 1'b1}, // R7 mismatch last byte
        '{2'd1, 1'b0, 1'b0, 1'b1, 6'd0,  8'd10, 8'd3, 1'b0, 3'b000, 8'd6, 1'b1}, // R5 trim
        '{2'd0, 1'b0, 1'b0, 1'b1, 6'd0,  8'd4,  8'd5, 1'b0, 3'b010, 8'd0, 1'b0}, // R6 pad too big
        '{2'd0, 1'b0, 1'b0, 1'b1, 6'd0,  8'd4,  8'd3, 1'b0, 3'b000, 8'd0, 1'b1}, // R5 trim to zero
        '{2'd2, 1'b1, 1'b1, 1'b0, 6'd4,  8'd3,  8'd0, 1'b0, 3'b000, 8'd3, 1'b1}, // R3 continue skips compare
        '{2'd0, 1'b0, 1'b1, 1'b1, 6'd20, 8'd9,  8'd2, 1'b1, 3'b001, 8'd6, 1'b1}  // R5 R7 trim + 20-byte icv
    };

    task automatic run(vec_t v, string tag);
        wr(1'b1, {58'd0, v.icv});
        wr(1'b0, mk(v.alg, v.cont, v.cicv, v.tls));
        chk({tag, " R4 write clears err"}, err, 0);
        done_cnt = 0; cmd_seen = 0;
        go();
        for (int i = 0; i < v.n; i++)
            push((i == v.n - 1) ? v.pad : 8'(i + 1), i == v.n - 1);
        if (v.cicv && !v.cont && v.ecause != 3'b010)
            for (int k = 0; k < v.icv; k++)
                push((v.bad && k == v.icv - 1) ? ~dbyte(k) : dbyte(k), 1'b0);
        repeat (12) @(negedge clk);
        chk({tag, " R9 one done"}, done_cnt, 1);
        chk({tag, " R7/R6 cause"}, err_cause, v.ecause);
        chk({tag, " R10 err"}, err, v.ecause != 0);
        chk({tag, " R6 cmd issued"}, cmd_seen, v.ecmd);
        if (v.ecmd) begin
            chk({tag, " R1 alg"}, c_alg, v.alg);
            chk({tag, " R2/R3 pad"}, c_pad, !v.cont);
            chk({tag, " R2/R3 final"}, c_fin, !v.cont);
            chk({tag, " R2/R5 len"}, c_len, v.elen);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        chk("R9 reset done", done, 0);
        chk("R10 reset err", err, 0);
        chk("R9 reset fifo_rd", fifo_rd, 0);
        chk("R2 reset cmd", core_cmd_valid, 0);

        for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i));

        // R10: error from last vector holds and blocks start
        done_cnt = 0; go(); repeat (8) @(negedge clk);
        chk("R10 err held", err, 1);
        chk("R10 start ignored", done_cnt, 0);

        // R4: inverse bit equal to continue
        begin logic [63:0] m = mk(2'd0, 1'b0, 1'b0, 1'b0); m[2] = 1'b0; wr(1'b0, m); end
        chk("R4 parity err", err, 1);
        chk("R4 parity cause", err_cause, 3'b100);
        begin logic [63:0] m = mk(2'd0, 1'b0, 1'b0, 1'b0); m[9] = 1'b0; wr(1'b1, 64'd4); wr(1'b0, m); end
        chk("R4 layout bit err", err, 1);
        begin logic [63:0] m = mk(2'd0, 1'b0, 1'b0, 1'b0); m[8] = 1'b1; wr(1'b1, 64'd4); wr(1'b0, m); end
        chk("R4 reserved bit err", err, 1);

        // R8: ICV size out of range for SHA-1, and zero
        wr(1'b1, 64'd21); wr(1'b0, mk(2'd0, 1'b0, 1'b1, 1'b0));
        done_cnt = 0; cmd_seen = 0; go(); repeat (6) @(negedge clk);
        chk("R8 size 21 cause", err_cause, 3'b100);
        chk("R8 size 21 done", done_cnt, 1);
        chk("R8 size 21 no cmd", cmd_seen, 0);
        chk("R8 size 21 no read", fifo_rd, 0);
        wr(1'b1, 64'd0);
        done_cnt = 0; go(); repeat (6) @(negedge clk);
        chk("R8 size 0 cause", err_cause, 3'b100);
        chk("R8 size 0 done", done_cnt, 1);

        // R11: writes during a job are ignored
        wr(1'b1, 64'd4); wr(1'b0, mk(2'd1, 1'b0, 1'b0, 1'b0));
        done_cnt = 0; cmd_seen = 0; go();
        wr(1'b0, mk(2'd3, 1'b1, 1'b0, 1'b0));
        push(8'h11, 1'b0); push(8'h22, 1'b1);
        repeat (10) @(negedge clk);
        chk("R11 alg unchanged", c_alg, 2'd1);
        chk("R11 pad unchanged", c_pad, 1);
        chk("R11 len", c_len, 2);
        chk("R11 done", done_cnt, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule